// File: doc/BRIEF.md
# Serial PCM Port with Frame-Sync Detection

This block moves 8-bit companded voice samples between a parallel host side and a serial time slot. Each frame it drives one byte out on a serial line with a tri-state enable, and it captures one byte from a serial input. A single bit clock serves both directions. Separate transmit and receive frame-sync inputs mark the start of each slot.

The port decides by itself whether short (one bit period) or long (three or more bit periods) frame-sync pulses are in use. It does this by counting how many falling bit-clock edges see the transmit sync high. It then moves the points where the output driver switches on and off to match the mode. The bit clock, both syncs and the serial input are all sampled by a much faster system clock through one shared synchronizer, and the port acts on the edges it detects. Each bit-clock phase must last at least four system clocks.

The host loads the next outgoing byte with a strobe at any time during a frame. A slot always sends the byte that was held when the slot began. A received byte is presented together with a single-cycle valid strobe.

Top module: `pcm_serial_port`

## Requirements
- R1: While reset is applied, `dout_oe` and `rx_valid` are 0. After reset the port is in short-sync mode.
- R2: In short-sync mode, a transmit sync that is high at a falling bit-clock edge makes the next rising edge turn `dout_oe` on, and `dout` carries bit 7 (the sign bit).
- R3: In short-sync mode, the seven rising edges after the sign bit shift out bits 6 down to 0 in that order. The falling edge after the last bit turns `dout_oe` off.
- R4: In long-sync mode, `dout_oe` turns on at whichever comes later: the rising edge of the transmit sync, or a rising bit-clock edge. The first bit driven is bit 7.
- R5: In long-sync mode, `dout_oe` turns off at whichever comes later: the falling bit-clock edge after the eighth rising edge, or the transmit sync going low.
- R6: In short-sync mode, a receive sync that is high at a falling bit-clock edge arms the receiver. The next eight falling edges capture `din` as bits 7 down to 0.
- R7: In long-sync mode, a rising edge on the receive sync makes the next eight falling bit-clock edges capture `din` as bits 7 down to 0.
- R8: A transmit sync pulse that spans three or more falling bit-clock edges selects long-sync mode. A pulse spanning one or two selects short-sync mode. The decision is taken when the pulse ends and governs the following frames.
- R9: The byte sent in a slot is the last one loaded with `tx_load` before the slot starts. A load during a slot is sent in the next slot.
- R10: Each completed receive slot produces exactly one single-cycle `rx_valid` pulse. `rx_data` changes only in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4 cycles per bit-clock phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bclk | input | 1 | Serial bit clock, shared by both directions |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| din | input | 1 | Serial receive data |
| tx_data | input | 8 | Next byte to send |
| tx_load | input | 1 | Strobe that captures `tx_data` |
| dout | output | 1 | Serial transmit data, valid while `dout_oe` is 1 |
| dout_oe | output | 1 | Output enable for the tri-state driver of `dout` |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` is updated |

## Verification
A wrong sync-mode decision shows up in the very next slot. `dout_oe` would rise one bit period early or late, and the sign bit would land in the wrong bit period. So every slot checks the enable at each bit-clock phase, plus every shifted bit. If a shift or capture counter is one off, the port ends the slot one phase early or late, or returns a receive byte rotated by one bit. The receive byte and the pulse count are compared at the end of the same slot. The frame sequence walks the mode detector through one, two, three, four, nine and ten period pulses. It also moves the transmit sync rise before, on and after a bit-clock rise, so the "whichever comes later" rules are exercised in both directions.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SHIFT = 2'd2,
    TX_TAIL  = 2'd3
  } tx_state_e;

  typedef enum logic {
    RX_IDLE    = 1'b0,
    RX_CAPTURE = 1'b1
  } rx_state_e;

  // Positions of the sampled pins inside the synchronizer vector
  localparam int unsigned PIN_BCLK = 0;
  localparam int unsigned PIN_FSX  = 1;
  localparam int unsigned PIN_FSR  = 2;
  localparam int unsigned PIN_DIN  = 3;
  localparam int unsigned PIN_CNT  = 4;
  localparam int unsigned EDGE_CNT = 2;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned E      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [E-1:0] rise,
  output logic [E-1:0] fall
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [E-1:0]             prev_q;

  // All pins share one pipeline so their relative order is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
      prev_q <= chain_q[STAGES-1][E-1:0];
    end
  end

  assign lvl = chain_q[STAGES-1];

  genvar i;
  generate
    for (i = 0; i < E; i++) begin : g_edge
      assign rise[i] = lvl[i] & ~prev_q[i];
      assign fall[i] = ~lvl[i] & prev_q[i];
    end
  endgenerate

endmodule

// File: rtl/pcm_frame_detect.sv
module pcm_frame_detect #(
  parameter int unsigned LONG_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic b_fall,
  input  logic fx_lvl,
  input  logic fx_rise,
  input  logic fx_fall,
  output logic long_mode
);

  localparam int unsigned CNT_W = $clog2(LONG_MIN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d;

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (fx_rise) begin
      cnt_d = b_fall ? CNT_W'(1) : '0;
    end else if (fx_lvl && b_fall && (cnt_q < CNT_W'(LONG_MIN))) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    if (fx_fall) begin
      mode_d = (cnt_q >= CNT_W'(LONG_MIN));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign long_mode = mode_q;

  // R8: the mode only changes right after the transmit sync ends
  p_mode_on_sync_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(fx_fall));

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
  import pcm_port_pkg::*;
#(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            long_mode,
  input  logic            b_lvl,
  input  logic            b_rise,
  input  logic            b_fall,
  input  logic            fx_lvl,
  input  logic            fx_rise,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  output logic            dx,
  output logic            dx_oe
);

  localparam int unsigned CNT_W = $clog2(BITS + 1);

  tx_state_e        state_q, state_d;
  logic [BITS-1:0]  hold_q, hold_d;
  logic [BITS-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    hold_d  = load ? load_data : hold_q;
    start   = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (long_mode) begin
          if (fx_rise) begin
            if (b_lvl) start = 1'b1;
            else       state_d = TX_ARMED;
          end
        end else if (b_fall && fx_lvl) begin
          state_d = TX_ARMED;
        end
      end
      TX_ARMED: begin
        if (b_rise) start = 1'b1;
      end
      TX_SHIFT: begin
        if (b_rise && (cnt_q != CNT_W'(BITS))) begin
          sh_d  = {sh_q[BITS-2:0], 1'b0};
          cnt_d = cnt_q + CNT_W'(1);
        end else if (b_fall && (cnt_q == CNT_W'(BITS))) begin
          state_d = (long_mode && fx_lvl) ? TX_TAIL : TX_IDLE;
        end
      end
      TX_TAIL: begin
        if (!fx_lvl) state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
    if (start) begin
      state_d = TX_SHIFT;
      sh_d    = hold_q;
      cnt_d   = CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      hold_q  <= '0;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
    end
  end

  assign dx    = sh_q[BITS-1];
  assign dx_oe = (state_q == TX_SHIFT) || (state_q == TX_TAIL);

  // R2 / R4: the driver only turns on after a bit-clock or sync rising edge
  p_oe_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_oe) |-> $past(b_rise || fx_rise));

  // R3: while driven, data moves only after a rising bit-clock edge
  p_dx_moves_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_oe && $past(dx_oe) && !$stable(dx)) |-> $past(b_rise));

  // R5: holding the driver past the last bit happens only in long mode
  p_tail_long_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_TAIL) |-> (long_mode && $past(fx_lvl)));

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
  import pcm_port_pkg::*;
#(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            long_mode,
  input  logic            b_fall,
  input  logic            fr_lvl,
  input  logic            d_lvl,
  output logic [BITS-1:0] rx_byte,
  output logic            rx_valid
);

  localparam int unsigned CNT_W = $clog2(BITS + 1);

  rx_state_e        state_q, state_d;
  logic [BITS-1:0]  sh_q, sh_d;
  logic [BITS-1:0]  byte_q, byte_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;
  logic             fr_prev_q;
  logic             fr_rise;
  logic             arm;

  assign fr_rise = fr_lvl & ~fr_prev_q;
  assign arm     = long_mode ? fr_rise : (b_fall && fr_lvl);

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    byte_d  = byte_q;
    cnt_d   = cnt_q;
    valid_d = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (arm) begin
          state_d = RX_CAPTURE;
          cnt_d   = '0;
        end
      end
      RX_CAPTURE: begin
        if (b_fall) begin
          sh_d  = {sh_q[BITS-2:0], d_lvl};
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(BITS - 1)) begin
            byte_d  = {sh_q[BITS-2:0], d_lvl};
            valid_d = 1'b1;
            state_d = RX_IDLE;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      sh_q      <= '0;
      byte_q    <= '0;
      cnt_q     <= '0;
      valid_q   <= 1'b0;
      fr_prev_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      sh_q      <= sh_d;
      byte_q    <= byte_d;
      cnt_q     <= cnt_d;
      valid_q   <= valid_d;
      fr_prev_q <= fr_lvl;
    end
  end

  assign rx_byte  = byte_q;
  assign rx_valid = valid_q;

  // R10: the strobe lasts exactly one cycle
  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R10: the presented byte only changes together with the strobe
  p_byte_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_valid);

  // R6 / R7: a byte is completed only on a falling bit-clock edge
  p_valid_after_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(b_fall));

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned BITS        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LONG_MIN    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk,
  input  logic            fsx,
  input  logic            fsr,
  input  logic            din,
  input  logic [BITS-1:0] tx_data,
  input  logic            tx_load,
  output logic            dout,
  output logic            dout_oe,
  output logic [BITS-1:0] rx_data,
  output logic            rx_valid
);

  logic [1:0]          rst_q;
  logic                rst_ni;
  logic [PIN_CNT-1:0]  pins;
  logic [PIN_CNT-1:0]  lvl;
  logic [EDGE_CNT-1:0] rise;
  logic [EDGE_CNT-1:0] fall;
  logic                long_mode;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  always_comb begin
    pins           = '0;
    pins[PIN_BCLK] = bclk;
    pins[PIN_FSX]  = fsx;
    pins[PIN_FSR]  = fsr;
    pins[PIN_DIN]  = din;
  end

  pcm_edge_sync #(
    .W      (PIN_CNT),
    .E      (EDGE_CNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_ni),
    .async_in (pins),
    .lvl      (lvl),
    .rise     (rise),
    .fall     (fall)
  );

  pcm_frame_detect #(
    .LONG_MIN (LONG_MIN)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_ni),
    .b_fall    (fall[PIN_BCLK]),
    .fx_lvl    (lvl[PIN_FSX]),
    .fx_rise   (rise[PIN_FSX]),
    .fx_fall   (fall[PIN_FSX]),
    .long_mode (long_mode)
  );

  pcm_tx_ser #(
    .BITS (BITS)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_ni),
    .long_mode (long_mode),
    .b_lvl     (lvl[PIN_BCLK]),
    .b_rise    (rise[PIN_BCLK]),
    .b_fall    (fall[PIN_BCLK]),
    .fx_lvl    (lvl[PIN_FSX]),
    .fx_rise   (rise[PIN_FSX]),
    .load      (tx_load),
    .load_data (tx_data),
    .dx        (dout),
    .dx_oe     (dout_oe)
  );

  pcm_rx_deser #(
    .BITS (BITS)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_ni),
    .long_mode (long_mode),
    .b_fall    (fall[PIN_BCLK]),
    .fr_lvl    (lvl[PIN_FSR]),
    .d_lvl     (lvl[PIN_DIN]),
    .rx_byte   (rx_data),
    .rx_valid  (rx_valid)
  );

  // R1: nothing is driven or strobed while reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_ni |-> (!dout_oe && !rx_valid));

endmodule

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bclk, fsx, fsr, din, tx_load;
  logic [7:0] tx_data;
  logic       dout, dout_oe, rx_valid;
  logic [7:0] rx_data;

  int   errors = 0;
  int   checks = 0;
  int   vcount = 0;
  logic [7:0] vbyte = 8'h00;
  bit   done = 1'b0;
  bit   exp_long = 1'b0;
  logic [7:0] cur_tx;

  always #2 clk = ~clk;

  pcm_serial_port uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (bclk),
    .fsx      (fsx),
    .fsr      (fsr),
    .din      (din),
    .tx_data  (tx_data),
    .tx_load  (tx_load),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid === 1'b1) begin
      vcount = vcount + 1;
      vbyte  = rx_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ph(input logic b, input logic fx, input logic fr, input logic d,
                    input int n, input bit ld, input logic [7:0] ldv);
    bclk = b; fsx = fx; fsr = fr; din = d;
    if (ld) begin
      tx_data = ldv;
      tx_load = 1'b1;
    end
    @(negedge clk);
    tx_load = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // vmode: 0 sync rises with a bit-clock rise, 1 rises mid high phase,
  //        2 rises at the falling edge before the slot
  task automatic run_frame(input int len, input int vmode,
                           input logic [7:0] next_tx, input logic [7:0] rxv);
    int last;
    int vstart;
    last   = (len + 2 > 10) ? len + 2 : 10;
    vstart = vcount;
    for (int p = -1; p <= last; p++) begin
      logic fxa, fxh, fxl, frh, dbit;
      bit   eo_h, eo_l;
      frh = (p >= 0 && p < len);
      fxh = frh;
      fxl = frh;
      fxa = frh;
      if (vmode == 1) fxa = (p >= 1 && p <= len);
      if (vmode == 2) fxl = (p >= -1 && p <= len - 2);
      if (exp_long) dbit = (p >= 0 && p <= 7) ? rxv[7-p] : p[0];
      else          dbit = (p >= 1 && p <= 8) ? rxv[8-p] : p[0];

      if (vmode == 1) begin
        ph(1'b1, fxa, frh, dbit, 4, (p == 4), next_tx);
        ph(1'b1, fxh, frh, dbit, 4, 1'b0, 8'h00);
      end else begin
        ph(1'b1, fxh, frh, dbit, 8, (p == 4), next_tx);
      end

      if (exp_long) begin
        eo_h = (p >= 0) && (p <= 7 || p < len);
        eo_l = (p >= 0) && (p < 7 || p < ((vmode == 2) ? len - 1 : len));
      end else begin
        eo_h = (p >= 1 && p <= 8);
        eo_l = (p >= 1 && p <= 7);
      end
      chk(dout_oe === eo_h, exp_long ? "R4 enable at rising phase" : "R2 enable at rising phase",
          int'(dout_oe), int'(eo_h));
      if (p == 0) chk(dout_oe === exp_long, "R8 mode seen at first bit", int'(dout_oe), int'(exp_long));
      if (exp_long && p >= 0 && p <= 7)
        chk(dout === cur_tx[7-p], "R9 long-mode bit from previous load", int'(dout), int'(cur_tx[7-p]));
      if (!exp_long && p >= 1 && p <= 8)
        chk(dout === cur_tx[8-p], "R3 short-mode bit order", int'(dout), int'(cur_tx[8-p]));

      ph(1'b0, fxl, frh, dbit, 8, 1'b0, 8'h00);
      chk(dout_oe === eo_l, exp_long ? "R5 enable at falling phase" : "R3 enable at falling phase",
          int'(dout_oe), int'(eo_l));
    end
    chk(vcount == vstart + 1, "R10 one strobe per slot", vcount - vstart, 1);
    chk(vbyte === rxv, exp_long ? "R7 long-mode received byte" : "R6 short-mode received byte",
        int'(vbyte), int'(rxv));
    cur_tx   = next_tx;
    exp_long = (len >= 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lens [18];
    int vms  [18];
    lens = '{1, 1, 1, 1, 2, 1, 3, 3, 4, 10, 3, 9, 4, 9, 2, 1, 4, 1};
    vms  = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0,  1, 1, 2, 2, 0, 0, 0, 0};
    rst_n = 1'b0; bclk = 1'b0; fsx = 1'b0; fsr = 1'b0; din = 1'b0;
    tx_load = 1'b0; tx_data = 8'h00;
    repeat (5) @(negedge clk);
    chk(dout_oe === 1'b0, "R1 enable low in reset", int'(dout_oe), 0);
    chk(rx_valid === 1'b0, "R1 strobe low in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(dout_oe === 1'b0, "R1 enable low after reset", int'(dout_oe), 0);

    tx_data = 8'hA5; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    cur_tx  = 8'hA5;
    exp_long = 1'b0;

    for (int i = 0; i < 18; i++) begin
      run_frame(lens[i], vms[i], 8'((i * 53 + 17) & 255), 8'((i * 29 + 101) & 255));
    end
    for (int i = 0; i < 32; i++) begin
      int vm;
      vm = exp_long ? (i % 3) : 0;
      run_frame((i % 4) + 1, vm, 8'((i * 71 + 200) & 255), 8'((i * 37 + 9) & 255));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule